// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Threshold Unit

This unit sits beside the storage array of a FIFO and turns the occupancy count into two active-low early-warning flags. One flag warns that the queue is nearly drained, the other that it is nearly filled. Each warning compares against its own offset register. The empty-side offset counts entries above zero. The full-side offset counts free slots below the depth.

The offsets start from one of eight presets chosen while master reset is held. They can later be rewritten in either of two ways. A parallel path takes one 36-bit word per write and alternates between the two registers. A serial path takes one bit per enabled cycle. A parallel read-back path returns the registers in the same alternating order, whichever way they were loaded. A configuration pin sampled at reset chooses whether the 36-bit word carries a parity bit in each byte lane. A second pin sampled at reset chooses between registered flags, each updated only on its own side's tick, and combinational flags that follow occupancy at once. A partial reset rewinds the access sequences and the flag state but keeps the offsets.

Top module: `prog_flag_unit`

## Requirements
- R1: While rst_ni is low, the index {ld_i, cfg_sel_i[1], cfg_sel_i[0]} (0 to 7) selects the preset 8*2^index - 1 (7, 15, ..., 1023). This value is loaded into both offsets and clamped to 2^OFS_W - 1.
- R2: pae_no is low exactly when occ_i is less than or equal to the empty-side offset.
- R3: paf_no is low exactly when DEPTH - occ_i is less than or equal to the full-side offset.
- R4: Each cycle with wr_en_i and ld_i high writes one offset. The first write goes to the empty-side offset and the next to the full-side offset, and the sequence then wraps back to the empty side.
- R5: When cfg_par_i was low at reset, the offset is taken from wr_d_i[31:0] and bits 35:32 are ignored. When cfg_par_i was high, bits 8, 17, 26 and 35 are skipped and the remaining bits are packed in ascending order.
- R6: Each cycle with ser_en_i and ld_i high and wr_en_i low takes ser_d_i as one bit. The first OFS_W bits fill the empty-side offset, LSB first, and the next OFS_W bits fill the full-side offset, LSB first, before the sequence wraps. A cycle with ser_en_i high and ld_i low changes nothing.
- R7: Each cycle with rd_en_i and ld_i high puts one offset on rd_q_o, empty side first and then full side, wrapping. The bit layout is the one R5 selects, with parity positions zero. Without such a cycle, rd_q_o holds its value.
- R8: part_rst_i keeps both offsets and rewinds the write, read and serial sequences to the empty side. In registered mode it drives pae_no low and paf_no high.
- R9: In registered mode (cfg_async_i low at reset), pae_no changes only on cycles with rd_tick_i and paf_no changes only on cycles with wr_tick_i. Each takes its R2/R3 value one cycle after the tick.
- R10: In combinational mode (cfg_async_i high at reset), both flags follow occ_i and the offsets with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low master reset; configuration pins are sampled while low |
| part_rst_i | input | 1 | Synchronous partial reset |
| cfg_sel_i | input | 2 | Preset index, low two bits |
| ld_i | input | 1 | Preset index bit 2 during reset; access qualifier afterwards |
| cfg_par_i | input | 1 | Parity-lane layout select, sampled at reset |
| cfg_async_i | input | 1 | Combinational flag mode select, sampled at reset |
| ser_en_i | input | 1 | Serial bit enable |
| ser_d_i | input | 1 | Serial data bit |
| wr_en_i | input | 1 | Parallel write enable |
| wr_d_i | input | 36 | Parallel offset word |
| rd_en_i | input | 1 | Parallel read-back enable |
| rd_q_o | output | 36 | Read-back word |
| wr_tick_i | input | 1 | Write-side update tick for the almost-full flag |
| rd_tick_i | input | 1 | Read-side update tick for the almost-empty flag |
| occ_i | input | OFS_W+1 | FIFO occupancy |
| pae_no | output | 1 | Almost-empty flag, active low |
| paf_no | output | 1 | Almost-full flag, active low |

## Verification
The bench builds the unit with DEPTH = 1024, which gives a 10-bit offset. At that width all eight presets fit without clamping, so every reset-time index produces a distinct read-back value. Offsets above 255 reach past bit 8, so the parity-lane skipping changes the packed value and the spread read-back layout. The 20-bit serial sequence stays short, and the full boundary at 1024 allows exact threshold checks on both flags.

// File: rtl/prog_flag_pkg.sv
package prog_flag_pkg;
  localparam int BUS_W = 36;
  localparam int LANE  = 9;
  localparam int PAY_W = BUS_W - BUS_W / LANE;

  // bus word -> payload; parity lanes drop bit 8 of each 9-bit lane
  function automatic logic [PAY_W-1:0] pack_word(input logic [BUS_W-1:0] d, input logic par);
    logic [PAY_W-1:0] r;
    int k;
    r = '0;
    k = 0;
    if (!par) r = d[PAY_W-1:0];
    else
      for (int i = 0; i < BUS_W; i++)
        if ((i % LANE) != LANE - 1) begin
          r[k] = d[i];
          k++;
        end
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] unpack_word(input logic [PAY_W-1:0] p, input logic par);
    logic [BUS_W-1:0] r;
    int k;
    r = '0;
    k = 0;
    if (!par) r[PAY_W-1:0] = p;
    else
      for (int i = 0; i < BUS_W; i++)
        if ((i % LANE) != LANE - 1) begin
          r[i] = p[k];
          k++;
        end
    return r;
  endfunction
endpackage

// File: rtl/pf_offset_regs.sv
module pf_offset_regs
  import prog_flag_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             part_rst_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic             ld_i,
  input  logic             cfg_par_i,
  input  logic             ser_en_i,
  input  logic             ser_d_i,
  input  logic             wr_en_i,
  input  logic [BUS_W-1:0] wr_d_i,
  input  logic             rd_en_i,
  output logic [BUS_W-1:0] rd_q_o,
  output logic [OFS_W-1:0] ofs_e_o,
  output logic [OFS_W-1:0] ofs_f_o
);
  localparam int BC_W = $clog2(2 * OFS_W);
  localparam int IX_W = (OFS_W > 1) ? $clog2(OFS_W) : 1;
  localparam logic [BC_W-1:0] OFS_BC  = BC_W'(OFS_W);
  localparam logic [BC_W-1:0] LAST_BC = BC_W'(2 * OFS_W - 1);
  localparam logic [31:0] MAXV = 32'((64'd1 << OFS_W) - 1);

  logic             par_q;
  logic             wptr_q, rptr_q;
  logic [BC_W-1:0]  bcnt_q, bidx;
  logic [OFS_W-1:0] ofs_e_q, ofs_f_q, dflt;
  logic [31:0]      dflt_raw;
  logic [PAY_W-1:0] asm_w;
  logic             par_ld, ser_ld, rb;

  assign par_ld = wr_en_i & ld_i;
  assign ser_ld = ser_en_i & ld_i & ~wr_en_i;
  assign rb     = rd_en_i & ld_i;
  assign asm_w  = pack_word(wr_d_i, par_q);
  assign bidx   = (bcnt_q < OFS_BC) ? bcnt_q : bcnt_q - OFS_BC;

  always_comb begin
    dflt_raw = (32'd8 << {ld_i, cfg_sel_i}) - 32'd1;
    dflt = (dflt_raw > MAXV) ? OFS_W'(MAXV) : OFS_W'(dflt_raw);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q   <= cfg_par_i;
      ofs_e_q <= dflt;
      ofs_f_q <= dflt;
      wptr_q  <= 1'b0;
      rptr_q  <= 1'b0;
      bcnt_q  <= '0;
      rd_q_o  <= '0;
    end else if (part_rst_i) begin
      wptr_q <= 1'b0;
      rptr_q <= 1'b0;
      bcnt_q <= '0;
    end else begin
      if (par_ld) begin
        if (!wptr_q) ofs_e_q <= asm_w[OFS_W-1:0];
        else         ofs_f_q <= asm_w[OFS_W-1:0];
        wptr_q <= ~wptr_q;
      end else if (ser_ld) begin
        if (bcnt_q < OFS_BC) ofs_e_q[bidx[IX_W-1:0]] <= ser_d_i;
        else                 ofs_f_q[bidx[IX_W-1:0]] <= ser_d_i;
        bcnt_q <= (bcnt_q == LAST_BC) ? '0 : bcnt_q + 1'b1;
      end
      if (rb) begin
        rd_q_o <= unpack_word(PAY_W'(rptr_q ? ofs_f_q : ofs_e_q), par_q);
        rptr_q <= ~rptr_q;
      end
    end
  end

  assign ofs_e_o = ofs_e_q;
  assign ofs_f_o = ofs_f_q;

  assert_ofs_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_ld && !(ser_en_i && ld_i)) |=> ($stable(ofs_e_q) && $stable(ofs_f_q)));
  assert_seq_rewind_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    part_rst_i |=> (!wptr_q && !rptr_q && bcnt_q == '0));
  assert_wptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_ld && !part_rst_i) |=> (wptr_q != $past(wptr_q)));
  assert_rb_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rb |=> $stable(rd_q_o));
  assert_bcnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcnt_q <= LAST_BC);
endmodule

// File: rtl/pf_flag_eval.sv
module pf_flag_eval #(
  parameter int DEPTH = 1024,
  parameter int OFS_W = 10,
  parameter int OCC_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             part_rst_i,
  input  logic             cfg_async_i,
  input  logic             wr_tick_i,
  input  logic             rd_tick_i,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [OFS_W-1:0] ofs_e_i,
  input  logic [OFS_W-1:0] ofs_f_i,
  output logic             pae_no,
  output logic             paf_no
);
  logic             async_q, pae_q, paf_q, near_e, near_f;
  logic [OCC_W-1:0] free_w;

  assign free_w = OCC_W'(DEPTH) - occ_i;
  assign near_e = occ_i <= OCC_W'(ofs_e_i);
  assign near_f = free_w <= OCC_W'(ofs_f_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      async_q <= cfg_async_i;
      pae_q   <= 1'b0;
      paf_q   <= 1'b1;
    end else if (part_rst_i) begin
      pae_q <= 1'b0;
      paf_q <= 1'b1;
    end else begin
      if (rd_tick_i) pae_q <= ~near_e;
      if (wr_tick_i) paf_q <= ~near_f;
    end
  end

  assign pae_no = async_q ? ~near_e : pae_q;
  assign paf_no = async_q ? ~near_f : paf_q;

  assert_pae_tick_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_q && !rd_tick_i && !part_rst_i) |=> $stable(pae_no));
  assert_paf_tick_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_q && !wr_tick_i && !part_rst_i) |=> $stable(paf_no));
  assert_prst_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_q && part_rst_i) |=> (!pae_no && paf_no));
  assert_async_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (async_q && occ_i == '0) |-> !pae_no);
endmodule

// File: rtl/prog_flag_unit.sv
module prog_flag_unit
  import prog_flag_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int OFS_W = $clog2(DEPTH),
  localparam int OCC_W = OFS_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             part_rst_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic             ld_i,
  input  logic             cfg_par_i,
  input  logic             cfg_async_i,
  input  logic             ser_en_i,
  input  logic             ser_d_i,
  input  logic             wr_en_i,
  input  logic [35:0]      wr_d_i,
  input  logic             rd_en_i,
  output logic [35:0]      rd_q_o,
  input  logic             wr_tick_i,
  input  logic             rd_tick_i,
  input  logic [OCC_W-1:0] occ_i,
  output logic             pae_no,
  output logic             paf_no
);
  logic [OFS_W-1:0] ofs_e, ofs_f;

  pf_offset_regs #(.OFS_W(OFS_W)) u_regs (
    .clk_i, .rst_ni, .part_rst_i, .cfg_sel_i, .ld_i, .cfg_par_i,
    .ser_en_i, .ser_d_i, .wr_en_i, .wr_d_i, .rd_en_i, .rd_q_o,
    .ofs_e_o(ofs_e), .ofs_f_o(ofs_f)
  );

  pf_flag_eval #(.DEPTH(DEPTH), .OFS_W(OFS_W), .OCC_W(OCC_W)) u_flags (
    .clk_i, .rst_ni, .part_rst_i, .cfg_async_i, .wr_tick_i, .rd_tick_i,
    .occ_i, .ofs_e_i(ofs_e), .ofs_f_i(ofs_f), .pae_no, .paf_no
  );
endmodule

// File: tb/sim_prog_flag_unit.sv
module sim_prog_flag_unit;
  logic clk = 0, rst_ni = 1, part_rst = 0;
  logic [1:0] cfg_sel = 0;
  logic ld = 0, cfg_par = 0, cfg_async = 0, ser_en = 0, ser_d = 0;
  logic wr_en = 0, rd_en = 0, wr_tick = 0, rd_tick = 0;
  logic [35:0] wr_d = 0, rd_q;
  logic [10:0] occ = 0;
  logic pae_n, paf_n;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  prog_flag_unit #(.DEPTH(1024)) u0 (
    .clk_i(clk), .rst_ni, .part_rst_i(part_rst), .cfg_sel_i(cfg_sel), .ld_i(ld),
    .cfg_par_i(cfg_par), .cfg_async_i(cfg_async), .ser_en_i(ser_en), .ser_d_i(ser_d),
    .wr_en_i(wr_en), .wr_d_i(wr_d), .rd_en_i(rd_en), .rd_q_o(rd_q),
    .wr_tick_i(wr_tick), .rd_tick_i(rd_tick), .occ_i(occ), .pae_no(pae_n), .paf_no(paf_n)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_rst(input int idx, input logic par, input logic asy);
    @(negedge clk);
    rst_ni = 0; cfg_sel = 2'(idx); ld = idx[2]; cfg_par = par; cfg_async = asy; occ = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1; ld = 0;
  endtask

  task automatic pw(input logic [35:0] d);
    @(negedge clk); wr_en = 1; ld = 1; wr_d = d;
    @(negedge clk); wr_en = 0; ld = 0;
  endtask

  task automatic rb(input string req, input logic [35:0] exp);
    @(negedge clk); rd_en = 1; ld = 1;
    @(negedge clk); rd_en = 0; ld = 0;
    chk(req, rd_q, exp);
  endtask

  task automatic sbits(input int v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ser_en = 1; ld = 1; ser_d = v[i];
    end
    @(negedge clk); ser_en = 0; ld = 0;
  endtask

  task automatic ticks(input logic w, input logic r);
    @(negedge clk); wr_tick = w; rd_tick = r;
    @(negedge clk); wr_tick = 0; rd_tick = 0;
  endtask

  task automatic t_defaults;
    for (int idx = 0; idx < 8; idx++) begin
      do_rst(idx, 0, 1);
      chk("R1 reset rd_q", rd_q, 0);
      rb("R1 empty preset", 36'((8 << idx) - 1));
      rb("R1 full preset", 36'((8 << idx) - 1));
    end
  endtask

  task automatic t_parallel;
    do_rst(0, 0, 1);
    pw({4'hF, 32'd100});
    pw(36'd200);
    rb("R5 bits 35:32 ignored", 36'd100);
    rb("R4 second write to full side", 36'd200);
    pw(36'd300);
    rb("R4 third write wraps to empty", 36'd300);
    rb("R7 read-back wraps", 36'd200);
    repeat (3) @(negedge clk);
    chk("R7 rd_q holds", rd_q, 36'd200);
  endtask

  task automatic t_parity;
    logic [35:0] w;
    do_rst(0, 1, 1);
    w = 36'd1112 | (36'd1 << 8) | (36'd1 << 17) | (36'd1 << 26) | (36'd1 << 35);
    pw(w);
    pw(36'd1112);
    rb("R5 parity lanes skipped", 36'd1112);
    rb("R7 spread layout", 36'd1112);
    @(negedge clk); occ = 600; #1;
    chk("R5 packed offset 600 pae", pae_n, 0);
    occ = 601; #1;
    chk("R5 packed offset 600 pae above", pae_n, 1);
    occ = 0;
  endtask

  task automatic t_serial;
    do_rst(0, 0, 1);
    sbits(5, 10);
    @(negedge clk); ser_en = 1; ld = 0; ser_d = 1;
    @(negedge clk); ser_en = 0;
    sbits(9, 10);
    rb("R6 serial empty offset", 36'd5);
    rb("R6 serial full offset", 36'd9);
    @(negedge clk); occ = 5; #1; chk("R6 pae at serial offset", pae_n, 0);
    occ = 6; #1; chk("R6 pae above serial offset", pae_n, 1);
    occ = 1015; #1; chk("R6 paf at serial offset", paf_n, 0);
    occ = 1014; #1; chk("R6 paf below serial offset", paf_n, 1);
    occ = 0;
  endtask

  task automatic t_async;
    do_rst(0, 0, 1);
    @(negedge clk); occ = 7; #1;
    chk("R2 pae at offset", pae_n, 0);
    chk("R10 async no clock", paf_n, 1);
    occ = 8; #1; chk("R2 pae above offset", pae_n, 1);
    occ = 1017; #1; chk("R3 paf at offset", paf_n, 0);
    occ = 1016; #1; chk("R3 paf above offset", paf_n, 1);
    occ = 0;
  endtask

  task automatic t_sync;
    do_rst(0, 0, 0);
    @(negedge clk);
    chk("R9 reset pae", pae_n, 0);
    chk("R9 reset paf", paf_n, 1);
    occ = 20;
    repeat (3) @(negedge clk);
    chk("R9 pae waits for read tick", pae_n, 0);
    ticks(1, 0);
    chk("R9 write tick leaves pae", pae_n, 0);
    ticks(0, 1);
    chk("R9 read tick updates pae", pae_n, 1);
    occ = 1020;
    ticks(0, 1);
    chk("R9 read tick leaves paf", paf_n, 1);
    ticks(1, 0);
    chk("R9 write tick updates paf", paf_n, 0);
    occ = 3;
    ticks(0, 1);
    chk("R9 pae drops on read tick", pae_n, 0);
    chk("R9 paf still held", paf_n, 0);
  endtask

  task automatic t_part_rst;
    do_rst(0, 0, 0);
    pw(36'd50); pw(36'd60); pw(36'd70);
    rb("R4 wrapped write", 36'd70);
    occ = 1020;
    ticks(1, 1);
    chk("R3 sync paf low", paf_n, 0);
    chk("R2 sync pae high", pae_n, 1);
    @(negedge clk); occ = 0; part_rst = 1;
    @(negedge clk); part_rst = 0;
    chk("R8 pae after partial reset", pae_n, 0);
    chk("R8 paf after partial reset", paf_n, 1);
    rb("R8 empty offset kept", 36'd70);
    rb("R8 full offset kept", 36'd60);
    pw(36'd80);
    rb("R8 write sequence rewound", 36'd80);
    rb("R8 full side untouched", 36'd60);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_defaults();
    t_parallel();
    t_parity();
    t_serial();
    t_async();
    t_sync();
    t_part_rst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule